// File: doc/BRIEF.md
# Selectable-Ratio PLL Reference Divider Chain

This block divides clocks down to the frequency that a phase-locked loop's comparator sees. It has two counters. The first is a prescaler with four fixed ratios, 4, 16, 64 and 100, chosen by a two-bit select. The second is a 4-bit binary divide-by-N counter whose ratio comes from a parallel preset. Each counter marks the end of its divide cycle with a pulse that is one clock wide.

A mode input sets how the two counters are connected. In chained mode the prescaler pulses step the N counter. The comparator output then carries the N counter's pulse, and the overall ratio is prescaler ratio times N. In independent mode the N counter counts every rising edge of its own auxiliary clock. The comparator output then carries the prescaler pulse alone.

A change to the ratio select or to the preset is picked up only when the affected counter next wraps, so no shortened period is produced. A preset of zero is not a valid ratio. The N counter reports it with an error flag and keeps its pulse low. A synchronous active-high reset starts both counters at the beginning of a divide cycle. The mode input is meant to change only while reset is held, because it selects the N counter's clock.

Top module: `pll_ref_divider`

## Requirements
- R1: The prescaler ratio is set by ratio_sel: 2'b00 divides by 4, 2'b01 by 16, 2'b10 by 64 and 2'b11 by 100. pre_pulse repeats with exactly that period in ref_clk cycles.
- R2: pre_pulse is high for one ref_clk cycle per period. The first pulse after reset is released appears after the ratio-th rising edge of ref_clk.
- R3: When chain_mode is 0, the N counter counts every aux_clk rising edge. n_pulse is one cycle wide and repeats every N edges, for a preset N from 1 to 15. The first pulse comes after the N-th edge following reset.
- R4: A zero preset sets preset_err high and keeps n_pulse low. Once the preset is non-zero, the next counting edge clears preset_err and reloads the counter. The first pulse then follows N counting edges later.
- R5: When chain_mode is 1, the N counter advances only on cycles where pre_pulse is high. cmp_out carries n_pulse, with period ratio*N ref_clk cycles and its first pulse at ratio*N+1 cycles after reset.
- R6: When chain_mode is 0, cmp_out carries pre_pulse.
- R7: A change of ratio_sel takes effect at the next prescaler wrap. The period already under way keeps the old ratio.
- R8: A change of preset takes effect at the next N-counter wrap. The period already under way keeps the old N.
- R9: While rst is high, pre_pulse, n_pulse and cmp_out are low. preset_err shows whether the preset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Prescaler clock; also clocks the N counter in chained mode |
| aux_clk | input | 1 | N counter clock in independent mode |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Prescaler ratio select (4/16/64/100) |
| preset | input | 4 | Divide ratio N for the N counter, 1 to 15 |
| chain_mode | input | 1 | 1: counters chained, N counter output to comparator; 0: independent |
| pre_pulse | output | 1 | Prescaler wrap pulse |
| n_pulse | output | 1 | N counter wrap pulse |
| cmp_out | output | 1 | Divided signal to the phase comparator |
| preset_err | output | 1 | Zero preset is in use |

## Verification
The bench measures the time to the first pulse and the spacing between pulses for every prescaler ratio, in both modes. This exposes a ratio decode that is off by one or swapped, and a chain that counts prescaler cycles one too many or one too few. It changes the select and the preset in the middle of a period. A design that applies them at once would give one period of the wrong length. It drives a zero preset and then a legal one. A design that divides by 16 or sticks in the error state would pulse when it must not, or never recover. It also tests N=1 in chained mode, where a counter that skips its first pulse would show a doubled period.

// File: rtl/pll_ref_divider.sv
module pll_ref_divider #(
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 16,
  parameter int RATIO2 = 64,
  parameter int RATIO3 = 100,
  parameter int NW     = 4,
  localparam int PW    = $clog2(RATIO3)
) (
  input  logic          ref_clk,
  input  logic          aux_clk,
  input  logic          rst,
  input  logic [1:0]    ratio_sel,
  input  logic [NW-1:0] preset,
  input  logic          chain_mode,
  output logic          pre_pulse,
  output logic          n_pulse,
  output logic          cmp_out,
  output logic          preset_err
);
  logic [PW-1:0] pcnt, pload;
  logic [NW-1:0] ncnt, nload;
  logic          n_clk, n_en;

  always_comb begin
    case (ratio_sel)
      2'b00:   pload = PW'(RATIO0 - 1);
      2'b01:   pload = PW'(RATIO1 - 1);
      2'b10:   pload = PW'(RATIO2 - 1);
      default: pload = PW'(RATIO3 - 1);
    endcase
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      pcnt      <= pload;
      pre_pulse <= 1'b0;
    end else if (pcnt == '0) begin
      pcnt      <= pload;
      pre_pulse <= 1'b1;
    end else begin
      pcnt      <= pcnt - 1'b1;
      pre_pulse <= 1'b0;
    end
  end

  assign n_clk = chain_mode ? ref_clk : aux_clk;
  assign n_en  = chain_mode ? pre_pulse : 1'b1;
  assign nload = preset - 1'b1;

  always_ff @(posedge n_clk) begin
    if (rst) begin
      ncnt       <= nload;
      n_pulse    <= 1'b0;
      preset_err <= (preset == '0);
    end else if (n_en) begin
      if (preset_err || ncnt == '0) begin
        ncnt       <= nload;
        preset_err <= (preset == '0);
      end else begin
        ncnt <= ncnt - 1'b1;
      end
      n_pulse <= !preset_err && (ncnt == '0);
    end else begin
      n_pulse <= 1'b0;
    end
  end

  assign cmp_out = chain_mode ? n_pulse : pre_pulse;
endmodule

// File: rtl/pll_ref_divider_chk.sv
module pll_ref_divider_chk (
  input logic ref_clk,
  input logic n_clk,
  input logic rst,
  input logic chain_mode,
  input logic pre_pulse,
  input logic n_pulse,
  input logic preset_err
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      gap  <= 8'd0;
      seen <= 1'b0;
    end else if (pre_pulse) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap  <= gap + 8'd1;
    end
  end

  assert_legal_gap_R1: assert property (@(posedge ref_clk) disable iff (rst)
    (pre_pulse && seen) |-> (gap == 8'd4 || gap == 8'd16 || gap == 8'd64 || gap == 8'd100));

  assert_pre_width_R2: assert property (@(posedge ref_clk) disable iff (rst)
    pre_pulse |=> !pre_pulse);

  assert_n_width_R3: assert property (@(posedge n_clk) disable iff (rst)
    n_pulse |=> !n_pulse);

  assert_err_silent_R4: assert property (@(posedge n_clk) disable iff (rst)
    $past(preset_err) |-> !n_pulse);

  assert_chain_step_R5: assert property (@(posedge ref_clk) disable iff (rst)
    (chain_mode && n_pulse) |-> $past(pre_pulse));
endmodule

bind pll_ref_divider pll_ref_divider_chk u_chk (.*);

// File: tb/sim_pll_ref_divider.sv
`timescale 1ns/1ps
module sim_pll_ref_divider;
  logic       ref_clk = 1'b0;
  logic       aux_clk;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic [3:0] preset = 4'd5;
  logic       chain_mode = 1'b0;
  logic       pre_pulse, n_pulse, cmp_out, preset_err;
  int errors = 0;
  int checks = 0;

  always #10 ref_clk = ~ref_clk;
  assign aux_clk = ref_clk;

  pll_ref_divider u0 (
    .ref_clk(ref_clk), .aux_clk(aux_clk), .rst(rst), .ratio_sel(ratio_sel),
    .preset(preset), .chain_mode(chain_mode), .pre_pulse(pre_pulse),
    .n_pulse(n_pulse), .cmp_out(cmp_out), .preset_err(preset_err)
  );

  // mode, sel, preset, first pulse cycle, period
  localparam int VEC [8][5] = '{
    '{0, 0,  5,    4,    4},
    '{0, 1,  5,   16,   16},
    '{0, 2,  5,   64,   64},
    '{0, 3,  5,  100,  100},
    '{1, 0,  3,   13,   12},
    '{1, 1,  2,   33,   32},
    '{1, 2,  1,   65,   64},
    '{1, 3, 15, 1501, 1500}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    case (w)
      1:       return pre_pulse;
      2:       return n_pulse;
      default: return cmp_out;
    endcase
  endfunction

  task automatic next_pulse(input int w, output int dt);
    dt = 0;
    do begin
      @(negedge ref_clk);
      dt++;
    end while (!sig(w) && dt < 5000);
  endtask

  task automatic do_reset(input logic m, input logic [1:0] s, input logic [3:0] p);
    @(negedge ref_clk);
    rst = 1'b1; chain_mode = m; ratio_sel = s; preset = p;
    repeat (3) @(negedge ref_clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dt;
    // R9: reset state
    repeat (3) @(negedge ref_clk);
    chk("R9 pre_pulse in reset", pre_pulse, 0);
    chk("R9 n_pulse in reset", n_pulse, 0);
    chk("R9 cmp_out in reset", cmp_out, 0);
    chk("R9 preset_err in reset", preset_err, 0);
    rst = 1'b0;

    // R1 R2 R5 R6: vector table
    for (int i = 0; i < 8; i++) begin
      do_reset(VEC[i][0][0], VEC[i][1][1:0], VEC[i][2][3:0]);
      next_pulse(0, dt);
      chk(VEC[i][0] ? "R5 first chained pulse" : "R6 first cmp pulse (R2)", dt, VEC[i][3]);
      @(negedge ref_clk);
      chk(VEC[i][0] ? "R5 cmp width" : "R2 cmp width", cmp_out, 0);
      next_pulse(0, dt);
      chk(VEC[i][0] ? "R5 chained period" : "R1 prescaler period", dt + 1, VEC[i][4]);
    end

    // R3: independent N counter
    do_reset(1'b0, 2'b00, 4'd7);
    next_pulse(2, dt);
    chk("R3 first n_pulse", dt, 7);
    // R8: preset change mid-period
    preset = 4'd3;
    next_pulse(2, dt);
    chk("R8 old N finishes", dt, 7);
    next_pulse(2, dt);
    chk("R8 new N applies", dt, 3);

    // R7: select change mid-period
    do_reset(1'b0, 2'b00, 4'd5);
    next_pulse(1, dt);
    ratio_sel = 2'b01;
    next_pulse(1, dt);
    chk("R7 old ratio finishes", dt, 4);
    next_pulse(1, dt);
    chk("R7 new ratio applies", dt, 16);

    // R4: zero preset, then recovery
    do_reset(1'b0, 2'b00, 4'd0);
    chk("R4 err after reset", preset_err, 1);
    begin
      int hits = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge ref_clk);
        if (n_pulse) hits++;
      end
      chk("R4 no pulse on zero preset", hits, 0);
    end
    chk("R4 err held", preset_err, 1);
    preset = 4'd3;
    @(negedge ref_clk);
    chk("R4 err cleared", preset_err, 0);
    next_pulse(2, dt);
    chk("R4 first pulse after recovery", dt + 1, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule